// File: doc/BRIEF.md
# Packet Buffer Page Allocator With Reservation

This block hands out fixed-size 2 KB buffer pages from a shared pool to a transmit requester and a receive requester. Each requester raises a one-cycle request and, one cycle later, sees either a grant with a page number or a fail pulse. Pages come back through a release port. Ownership is held in a free-page bitmap, and the lowest-numbered free page is always the one handed out.

A host-writable reservation value holds back memory for transmit. It is compared against the memory that is currently free, so it comes on top of whatever is already in use. A receive request is refused when the free memory, after any transmit grant in the same cycle, is at or below the reservation. A zero reservation leaves both directions fully dynamic. Transmit requests are never limited by the reservation. The free-memory readout and the reservation are both counted in 512-byte units, which is 256 bytes times a size multiplier of 2. A read-only upper byte of the configuration readout returns that multiplier.

A soft reset command returns every page to the pool in one cycle and leaves the reservation unchanged. The hardware reset clears the reservation to zero.

Top module: `page_alloc_rsv`

## Requirements
- R1: After hardware reset all 32 pages are free, `host_free_o` reads 128, the reservation reads 0 and `host_cfg_o` reads 0x0200.
- R2: A transmit request made while at least one page is free gets `tx_grant_o` for exactly one cycle, in the cycle after the request, together with the lowest-numbered free page on `tx_page_o`.
- R3: A transmit request made while no page is free gets `tx_fail_o` for one cycle and no grant.
- R4: With reservation 0, a receive request is granted the lowest free page whenever any page is free.
- R5: A receive request is refused with `rx_fail_o` when the free units, minus 4 if a transmit grant is made in the same cycle, are less than or equal to the effective reservation. Otherwise it is granted. Transmit grants ignore the reservation.
- R6: The effective reservation is the written byte with bits 1:0 cleared, so it counts only whole pages. The exception is a written value of 0xFF, which reserves everything, so every receive request fails.
- R7: When transmit and receive requests arrive in the same cycle, transmit takes the lowest free page and receive takes the next lowest. Receive is judged against the count left after the transmit grant.
- R8: A release of an allocated page makes it free again in the next cycle. A release of a page that is already free leaves `host_free_o` unchanged.
- R9: A `soft_rst_i` pulse makes all pages free in the next cycle and leaves the reservation unchanged. Requests made in that cycle fail.
- R10: `host_cfg_o[15:8]` always reads the multiplier 2. A host write changes only `host_cfg_o[7:0]`, in the next cycle.
- R11: `host_free_o` equals 4 times the number of free pages, one unit being 512 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_req_i | input | 1 | Transmit page request, one per cycle high |
| tx_grant_o | output | 1 | Transmit grant pulse |
| tx_fail_o | output | 1 | Transmit refusal pulse |
| tx_page_o | output | 5 | Page granted to transmit |
| rx_req_i | input | 1 | Receive page request, one per cycle high |
| rx_grant_o | output | 1 | Receive grant pulse |
| rx_fail_o | output | 1 | Receive refusal pulse |
| rx_page_o | output | 5 | Page granted to receive |
| rel_i | input | 1 | Page release strobe |
| rel_page_i | input | 5 | Page being released |
| soft_rst_i | input | 1 | Allocator soft reset command |
| host_we_i | input | 1 | Reservation write strobe |
| host_wdata_i | input | 8 | Reservation value in 512-byte units |
| host_cfg_o | output | 16 | Upper byte: multiplier, lower byte: reservation |
| host_free_o | output | 8 | Free memory in 512-byte units |

## Verification
A corrupted bitmap shows on `host_free_o` in the cycle after the bad update. It also shows as a wrong page number on the next grant, because the lowest free page shifts. A wrong reservation or a bad comparison shows only when a receive request lands close to the threshold. For that reason the bench drives the free count to exactly the reservation, one page above it, and zero, and checks the grant or fail pulse one cycle after each request. Same-cycle transmit and receive requests are run just above the threshold, so that the receive decision depends on the count left after the transmit grant.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;
  localparam int unsigned NUM_REQ_PORTS = 2;

  typedef enum int unsigned {
    PORT_TX = 0,
    PORT_RX = 1
  } req_port_e;

  typedef struct packed {
    logic grant;
    logic fail;
  } resp_t;
endpackage

// File: rtl/alloc_lowest_free.sv
module alloc_lowest_free #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/alloc_popcount.sv
module alloc_popcount #(
  parameter int unsigned N  = 32,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/alloc_rsv_reg.sv
module alloc_rsv_reg #(
  parameter int unsigned RSV_W          = 8,
  parameter int unsigned UNITS_PER_PAGE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RSV_W-1:0] wdata_i,
  output logic [RSV_W-1:0] rsv_o,
  output logic [RSV_W-1:0] eff_o
);
  localparam logic [RSV_W-1:0] SUB_PAGE = RSV_W'(UNITS_PER_PAGE - 1);

  logic [RSV_W-1:0] rsv_q;

  // hardware reset only; the soft allocator reset does not reach here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rsv_q <= '0;
    else if (we_i) rsv_q <= wdata_i;
  end

  // whole pages only, except all-ones which reserves everything
  always_comb begin
    if (&rsv_q) eff_o = rsv_q;
    else        eff_o = rsv_q & ~SUB_PAGE;
  end

  assign rsv_o = rsv_q;
endmodule

// File: rtl/alloc_resp_reg.sv
module alloc_resp_reg
  import page_alloc_pkg::*;
#(
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              ok_i,
  input  logic [PAGE_W-1:0] page_i,
  output resp_t             resp_o,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_o <= '0;
      page_o <= '0;
    end else begin
      resp_o.grant <= ok_i;
      resp_o.fail  <= req_i & ~ok_i;
      if (ok_i) page_o <= page_i;
    end
  end
endmodule

// File: rtl/page_alloc_rsv.sv
module page_alloc_rsv
  import page_alloc_pkg::*;
#(
  parameter int unsigned NUM_PAGES      = 32,
  parameter int unsigned UNITS_PER_PAGE = 4,
  parameter int unsigned MEM_MULT       = 2,
  parameter int unsigned RSV_W          = 8,
  localparam int unsigned PAGE_W        = $clog2(NUM_PAGES),
  localparam int unsigned FREE_W        = $clog2(NUM_PAGES * UNITS_PER_PAGE + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_req_i,
  output logic                tx_grant_o,
  output logic                tx_fail_o,
  output logic [PAGE_W-1:0]   tx_page_o,
  input  logic                rx_req_i,
  output logic                rx_grant_o,
  output logic                rx_fail_o,
  output logic [PAGE_W-1:0]   rx_page_o,
  input  logic                rel_i,
  input  logic [PAGE_W-1:0]   rel_page_i,
  input  logic                soft_rst_i,
  input  logic                host_we_i,
  input  logic [RSV_W-1:0]    host_wdata_i,
  output logic [2*RSV_W-1:0]  host_cfg_o,
  output logic [FREE_W-1:0]   host_free_o
);
  localparam int unsigned CNT_W = $clog2(NUM_PAGES + 1);
  localparam int unsigned CMP_W = ((FREE_W > RSV_W) ? FREE_W : RSV_W) + 1;

  logic [NUM_PAGES-1:0] free_q, free_d;
  logic [NUM_PAGES-1:0] tx_mask, rx_mask, rem_after_tx, rel_mask;
  logic [CNT_W-1:0]     free_pages;
  logic [FREE_W-1:0]    free_units;
  logic [CMP_W-1:0]     avail_for_rx;
  logic [RSV_W-1:0]     rsv_val, rsv_eff;
  logic                 tx_any, rx_any, tx_ok, rx_ok, rel_ok;
  logic [PAGE_W-1:0]    tx_idx, rx_idx;

  logic [NUM_REQ_PORTS-1:0] req_v, ok_v;
  logic [PAGE_W-1:0]        pg_v   [NUM_REQ_PORTS];
  logic [PAGE_W-1:0]        pg_q   [NUM_REQ_PORTS];
  resp_t                    resp_v [NUM_REQ_PORTS];

  alloc_popcount #(.N(NUM_PAGES), .CW(CNT_W)) u_cnt (
    .vec_i (free_q),
    .cnt_o (free_pages)
  );

  assign free_units = FREE_W'(free_pages * UNITS_PER_PAGE);

  alloc_rsv_reg #(.RSV_W(RSV_W), .UNITS_PER_PAGE(UNITS_PER_PAGE)) u_rsv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_we_i),
    .wdata_i (host_wdata_i),
    .rsv_o   (rsv_val),
    .eff_o   (rsv_eff)
  );

  // transmit is served first, from the lowest free page
  alloc_lowest_free #(.N(NUM_PAGES), .IW(PAGE_W)) u_enc_tx (
    .vec_i   (free_q),
    .found_o (tx_any),
    .idx_o   (tx_idx)
  );

  assign tx_ok        = tx_req_i & tx_any & ~soft_rst_i;
  assign tx_mask      = tx_ok ? (NUM_PAGES'(1) << tx_idx) : '0;
  assign rem_after_tx = free_q & ~tx_mask;

  alloc_lowest_free #(.N(NUM_PAGES), .IW(PAGE_W)) u_enc_rx (
    .vec_i   (rem_after_tx),
    .found_o (rx_any),
    .idx_o   (rx_idx)
  );

  // receive judged on what remains after a same-cycle transmit grant
  assign avail_for_rx = CMP_W'(free_units) - (tx_ok ? CMP_W'(UNITS_PER_PAGE) : '0);
  assign rx_ok        = rx_req_i & rx_any & ~soft_rst_i & (avail_for_rx > CMP_W'(rsv_eff));
  assign rx_mask      = rx_ok ? (NUM_PAGES'(1) << rx_idx) : '0;

  // releasing a page that is already free has no effect
  assign rel_ok   = rel_i & ~free_q[rel_page_i];
  assign rel_mask = rel_ok ? (NUM_PAGES'(1) << rel_page_i) : '0;

  always_comb begin
    if (soft_rst_i) free_d = '1;
    else            free_d = (free_q & ~tx_mask & ~rx_mask) | rel_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '1;
    else         free_q <= free_d;
  end

  assign req_v[PORT_TX] = tx_req_i;
  assign req_v[PORT_RX] = rx_req_i;
  assign ok_v[PORT_TX]  = tx_ok;
  assign ok_v[PORT_RX]  = rx_ok;
  assign pg_v[PORT_TX]  = tx_idx;
  assign pg_v[PORT_RX]  = rx_idx;

  for (genvar g = 0; g < NUM_REQ_PORTS; g++) begin : g_resp
    alloc_resp_reg #(.PAGE_W(PAGE_W)) u_resp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_v[g]),
      .ok_i   (ok_v[g]),
      .page_i (pg_v[g]),
      .resp_o (resp_v[g]),
      .page_o (pg_q[g])
    );
  end

  assign tx_grant_o = resp_v[PORT_TX].grant;
  assign tx_fail_o  = resp_v[PORT_TX].fail;
  assign tx_page_o  = pg_q[PORT_TX];
  assign rx_grant_o = resp_v[PORT_RX].grant;
  assign rx_fail_o  = resp_v[PORT_RX].fail;
  assign rx_page_o  = pg_q[PORT_RX];

  assign host_cfg_o  = {RSV_W'(MEM_MULT), rsv_val};
  assign host_free_o = free_units;
endmodule

// File: rtl/page_alloc_rsv_chk.sv
module page_alloc_rsv_chk #(
  parameter int unsigned NUM_PAGES      = 32,
  parameter int unsigned UNITS_PER_PAGE = 4,
  parameter int unsigned RSV_W          = 8,
  parameter int unsigned PAGE_W         = 5,
  parameter int unsigned FREE_W         = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tx_req_i,
  input logic               tx_grant_o,
  input logic               tx_fail_o,
  input logic [PAGE_W-1:0]  tx_page_o,
  input logic               rx_grant_o,
  input logic               rx_fail_o,
  input logic [PAGE_W-1:0]  rx_page_o,
  input logic               soft_rst_i,
  input logic               host_we_i,
  input logic [2*RSV_W-1:0] host_cfg_o,
  input logic [FREE_W-1:0]  host_free_o
);
  localparam int TOTAL_UNITS = NUM_PAGES * UNITS_PER_PAGE;

  logic [RSV_W-1:0] cfg_rsv;
  int               eff_units;

  assign cfg_rsv = host_cfg_o[RSV_W-1:0];

  always_comb begin
    if (&cfg_rsv) eff_units = int'(cfg_rsv);
    else          eff_units = int'(cfg_rsv) - (int'(cfg_rsv) % UNITS_PER_PAGE);
  end

  AST_TX_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_grant_o && tx_fail_o)); // R3

  AST_RX_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_grant_o && rx_fail_o)); // R5

  AST_TX_FAIL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fail_o |-> ($past(host_free_o) == '0 || $past(soft_rst_i))); // R3

  AST_TX_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grant_o |-> $past(tx_req_i)); // R2

  AST_RX_ABOVE_RSV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_grant_o |-> (int'($past(host_free_o)) - (tx_grant_o ? UNITS_PER_PAGE : 0)) > $past(eff_units)); // R5

  AST_TX_BELOW_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_grant_o && rx_grant_o) |-> (tx_page_o < rx_page_o)); // R7

  AST_SOFT_ALL_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(soft_rst_i) |-> (int'(host_free_o) == TOTAL_UNITS)); // R9

  AST_RSV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(host_we_i) |-> $stable(cfg_rsv)); // R9
endmodule

bind page_alloc_rsv page_alloc_rsv_chk #(
  .NUM_PAGES      (NUM_PAGES),
  .UNITS_PER_PAGE (UNITS_PER_PAGE),
  .RSV_W          (RSV_W),
  .PAGE_W         (PAGE_W),
  .FREE_W         (FREE_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_req_i    (tx_req_i),
  .tx_grant_o  (tx_grant_o),
  .tx_fail_o   (tx_fail_o),
  .tx_page_o   (tx_page_o),
  .rx_grant_o  (rx_grant_o),
  .rx_fail_o   (rx_fail_o),
  .rx_page_o   (rx_page_o),
  .soft_rst_i  (soft_rst_i),
  .host_we_i   (host_we_i),
  .host_cfg_o  (host_cfg_o),
  .host_free_o (host_free_o)
);

// File: tb/page_alloc_rsv_tb_top.sv
`timescale 1ns/1ps
module page_alloc_rsv_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tx_req, rx_req, rel, soft_rst, host_we;
  logic [4:0]  rel_page;
  logic [7:0]  host_wdata;
  logic        tx_grant, tx_fail, rx_grant, rx_fail;
  logic [4:0]  tx_page, rx_page;
  logic [15:0] host_cfg;
  logic [7:0]  host_free;

  always #10 clk = ~clk;

  page_alloc_rsv dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .tx_req_i     (tx_req),
    .tx_grant_o   (tx_grant),
    .tx_fail_o    (tx_fail),
    .tx_page_o    (tx_page),
    .rx_req_i     (rx_req),
    .rx_grant_o   (rx_grant),
    .rx_fail_o    (rx_fail),
    .rx_page_o    (rx_page),
    .rel_i        (rel),
    .rel_page_i   (rel_page),
    .soft_rst_i   (soft_rst),
    .host_we_i    (host_we),
    .host_wdata_i (host_wdata),
    .host_cfg_o   (host_cfg),
    .host_free_o  (host_free)
  );

  typedef struct {
    int    cyc;
    int    kind;
    int    exp;
    string tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        cur;
  int          cyc    = 0;
  int          n_cmp  = 0;
  int          n_bad  = 0;
  bit          done   = 1'b0;
  bit [31:0]   free_m = '1;
  int          rsv_m  = 0;

  localparam string KNAME [8] = '{"tx_grant", "tx_fail", "tx_page", "rx_grant",
                                   "rx_fail", "rx_page", "host_free", "host_cfg"};

  function automatic int actual(int k);
    case (k)
      0: return int'(tx_grant);
      1: return int'(tx_fail);
      2: return int'(tx_page);
      3: return int'(rx_grant);
      4: return int'(rx_fail);
      5: return int'(rx_page);
      6: return int'(host_free);
      default: return int'(host_cfg);
    endcase
  endfunction

  task automatic compare(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops due items and compares them against the ports
  always @(negedge clk) begin
    cyc++;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      cur = sb_q.pop_front();
      compare(cur.tag, KNAME[cur.kind], actual(cur.kind), cur.exp);
    end
  end

  function automatic int lowest(bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic push(int due, int kind, int exp, string tag);
    exp_t e;
    e.cyc = due; e.kind = kind; e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // driver: applies one cycle of stimulus and queues the expected response
  task automatic op(bit tx, bit rx, bit rl, int rp, bit sr, bit we, int wd, string tag);
    int        units, eff, avail, tp, rxp, due;
    bit        txo, rxo;
    bit [31:0] rem;
    @(posedge clk); #2;
    tx_req = tx; rx_req = rx; rel = rl; rel_page = 5'(rp);
    soft_rst = sr; host_we = we; host_wdata = 8'(wd);
    due   = cyc + 2;
    units = $countones(free_m) * 4;
    eff   = (rsv_m == 255) ? 255 : (rsv_m & 'hFC);
    avail = units;
    txo = 1'b0; rxo = 1'b0; tp = 0; rxp = 0;
    rem = free_m;
    if (!sr && tx && free_m != 0) begin
      txo = 1'b1; tp = lowest(free_m); rem[tp] = 1'b0; avail = units - 4;
    end
    if (!sr && rx && rem != 0 && avail > eff) begin
      rxo = 1'b1; rxp = lowest(rem); rem[rxp] = 1'b0;
    end
    if (sr) free_m = '1;
    else begin
      if (rl && !free_m[rp]) rem[rp] = 1'b1;
      free_m = rem;
    end
    if (we) rsv_m = wd;
    push(due, 0, int'(txo), tag);
    push(due, 1, int'(tx && !txo), tag);
    if (txo) push(due, 2, tp, tag);
    push(due, 3, int'(rxo), tag);
    push(due, 4, int'(rx && !rxo), tag);
    if (rxo) push(due, 5, rxp, tag);
    push(due, 6, $countones(free_m) * 4, tag);
    push(due, 7, 'h200 | rsv_m, tag);
    @(posedge clk); #2;
    tx_req = 0; rx_req = 0; rel = 0; soft_rst = 0; host_we = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    tx_req = 0; rx_req = 0; rel = 0; rel_page = '0; soft_rst = 0;
    host_we = 0; host_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1", "host_free", int'(host_free), 128);
    compare("R1", "host_cfg", int'(host_cfg), 'h0200);
    compare("R1", "tx_grant", int'(tx_grant), 0);
    rst_ni = 1'b1;

    op(0, 0, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) op(1, 0, 0, 0, 0, 0, 0, "R2");   // pages 0,1,2
    op(0, 0, 1, 1, 0, 0, 0, "R8");                               // free page 1
    op(0, 0, 1, 1, 0, 0, 0, "R8");                               // already free: ignored
    op(1, 0, 0, 0, 0, 0, 0, "R2");                               // page 1 again
    op(0, 1, 0, 0, 0, 0, 0, "R4");                               // rx gets page 3
    for (int i = 0; i < 26; i++) op(1, 0, 0, 0, 0, 0, 0, "R11"); // 2 pages left
    op(0, 0, 0, 0, 0, 1, 'h07, "R6");                            // effective 4
    op(0, 1, 0, 0, 0, 0, 0, "R5");                               // 8 > 4: grant
    op(0, 1, 0, 0, 0, 0, 0, "R5");                               // 4 <= 4: refuse
    op(0, 0, 0, 0, 0, 1, 'h03, "R6");                            // effective 0
    op(0, 1, 0, 0, 0, 0, 0, "R6");                               // last page
    op(1, 0, 0, 0, 0, 0, 0, "R3");                               // empty: fail
    op(1, 1, 0, 0, 0, 0, 0, "R3");
    op(1, 1, 0, 0, 1, 0, 0, "R9");                               // soft reset
    op(0, 0, 0, 0, 0, 0, 0, "R9");
    op(0, 0, 0, 0, 0, 1, 'hFF, "R6");                            // reserve all
    op(0, 1, 0, 0, 0, 0, 0, "R6");
    op(1, 0, 0, 0, 0, 0, 0, "R5");                               // tx unaffected
    op(0, 0, 0, 0, 0, 1, 'h74, "R7");                            // 116 units
    op(1, 1, 0, 0, 0, 0, 0, "R7");                               // 124-4=120 > 116
    op(1, 1, 0, 0, 0, 0, 0, "R7");                               // 116-4=112: rx refused
    op(0, 1, 0, 0, 0, 0, 0, "R5");
    op(0, 0, 0, 0, 0, 1, 'hAB, "R10");
    op(0, 0, 1, 2, 0, 0, 0, "R8");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule